// File: doc/BRIEF.md
# MII Management Frame Register with Built-in PHY Register Bank

This block gives software a single 32-bit frame register for PHY management. One write to it carries out a whole management transaction against a built-in bank of 32 sixteen-bit PHY registers. No serial MDIO clocking or pin timing is involved. The written word is split into start, opcode, PHY address, register address, turnaround and data fields. For a read, the data field is replaced with the addressed register's contents. In every case the turnaround LSB is set in the stored word, and software polls that bit to see that the transaction is done.

The bank models the self-clearing control bits of a typical PHY:
- A reset request turns on autonegotiation.
- An autonegotiation restart reports completion at once, and reports link state if the link is up.

A separate configuration register holds two transceiver-detect bits that software cannot change. An asynchronous link-status input is synchronized inside the block. Each change of that input updates the link bits in the bank and raises a 16-bit management status word to all ones. Software clears that word with a pulse.

Top module: `mgmt_frame_if`

## Requirements
- R1: A write to the frame register (reg_sel=0) stores the written word with bit 16 forced to 1. The fields are start [31:30], opcode [29:28], PHY address [27:23], register address [22:18], turnaround [17:16] and data [15:0]. The stored word appears on frame_q one cycle after the write.
- R2: If the start field is not 2'b01, or the PHY address differs from PHY_ADDR (default 1), no bank register is read or written. The stored word is still the written word with bit 16 set.
- R3: Opcode 2'b01 writes the data field into the addressed bank register. Opcode 2'b10 stores bits [31:17] as written, sets bit 16, and puts the addressed register's contents in bits [15:0].
- R4: A write to bank register 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R5: A write to bank register 0 with bit 9 set stores the value with bit 9 cleared and sets bit 5 of register 1. If the synchronized link is up, it also sets bit 2 of register 1 and bit 8 of register 5.
- R6: A write to the configuration register (reg_sel=1) updates every bit except bits 9:8, which keep their value. After reset cfg_q is 32'h0000_0100.
- R7: After reset the values are: frame_q 0, mgmt_status 0, register 1 16'h4028, register 2 ID_HI, register 3 ID_LO, register 4 16'h0100, register 5 0.
- R8: The link input passes through SYNC_STAGES flops. Each change of the synchronized value copies it into bit 2 of register 1 and bit 8 of register 5 and sets mgmt_status to 16'hFFFF. A stat_clr pulse clears mgmt_status. The synchronizer comes out of reset low, so a link already up at reset is reported as a change.
- R9: Opcodes 2'b00 and 2'b11 access no bank register. The data field is stored unchanged, with bit 16 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_a | input | 1 | Asynchronous link-status input |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the frame register, 1 selects the configuration register |
| wr_data | input | 32 | Write data |
| stat_clr | input | 1 | Clears the management status word |
| frame_q | output | 32 | Frame register contents |
| cfg_q | output | 32 | Configuration register contents |
| mgmt_status | output | 16 | Management status word |

## Verification
The embedded assertions check the following on every cycle:
- the turnaround bit after any frame write;
- that the configuration read-only bits hold across writes;
- the self-clearing reset and restart bits of register 0;
- the all-ones status after a link change;
- that read data lands in the frame register.

The directed scenarios cover the rest:
- whether a rejected or no-op frame leaves the bank untouched, which is visible only by reading registers back later;
- the full reset contents of the bank;
- the link-dependent side effects of an autonegotiation restart;
- the latency of the link synchronizer.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
   localparam int FRAME_W   = 32;
   localparam int ST_HI     = 31;
   localparam int OP_HI     = 29;
   localparam int PA_HI     = 27;
   localparam int RA_HI     = 22;
   localparam int TA_LSB    = 16;
   localparam int HDR_LO    = 18;

   localparam logic [1:0] ST_VALID = 2'b01;

   typedef enum logic [1:0] {
      OPC_NONE0 = 2'b00,
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10,
      OPC_NONE3 = 2'b11
   } mfi_opc_e;

   // bit positions inside the PHY bank
   localparam int CTL_RST_BIT   = 15;
   localparam int CTL_ANEN_BIT  = 12;
   localparam int CTL_ANRS_BIT  = 9;
   localparam int STS_LINK_BIT  = 2;
   localparam int STS_ANOK_BIT  = 5;
   localparam int LPA_FD100_BIT = 8;

   localparam int IDX_CTL = 0;
   localparam int IDX_STS = 1;
   localparam int IDX_ADV = 4;
   localparam int IDX_LPA = 5;

   localparam logic [15:0] STS_RST = 16'h4028;
   localparam logic [15:0] ADV_RST = 16'h0100;
   localparam logic [31:0] CFG_RO_MASK = 32'h0000_0300;
   localparam logic [31:0] CFG_RST     = 32'h0000_0100;
endpackage

// File: rtl/mfi_sync.sv
module mfi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_a,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mfi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d_a;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mfi_frame_dec.sv
module mfi_frame_dec
   import mfi_pkg::*;
#(
   parameter int          IDX_W    = 5,
   parameter logic [4:0]  PHY_ADDR = 5'd1
) (
   input  logic [13:0]      hdr,      // frame bits 31:18
   output logic             acc_ok,
   output logic             op_wr,
   output logic             op_rd,
   output logic [IDX_W-1:0] reg_idx
);
   if (IDX_W != 5) begin : g_bad_idx
      $error("mfi_frame_dec: register address field is 5 bits");
   end

   logic [1:0] st_f;
   mfi_opc_e   op_f;
   logic [4:0] pa_f;

   always_comb begin
      st_f    = hdr[ST_HI-HDR_LO -: 2];
      op_f    = mfi_opc_e'(hdr[OP_HI-HDR_LO -: 2]);
      pa_f    = hdr[PA_HI-HDR_LO -: 5];
      reg_idx = hdr[RA_HI-HDR_LO -: 5];
      acc_ok  = (st_f == ST_VALID) && (pa_f == PHY_ADDR);
      op_wr   = acc_ok && (op_f == OPC_WRITE);
      op_rd   = acc_ok && (op_f == OPC_READ);
   end
endmodule

// File: rtl/mfi_phy_bank.sv
module mfi_phy_bank
   import mfi_pkg::*;
#(
   parameter int          NUM_REGS = 32,
   parameter int          REG_W    = 16,
   parameter logic [15:0] ID_HI    = 16'h1234,
   parameter logic [15:0] ID_LO    = 16'h5670,
   localparam int         IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [REG_W-1:0] wr_data,
   input  logic             link_s,
   input  logic             link_evt,
   output logic [REG_W-1:0] rd_data
);
   if (REG_W != 16) begin : g_bad_w
      $error("mfi_phy_bank: REG_W must be 16");
   end
   if (NUM_REGS < 6) begin : g_bad_n
      $error("mfi_phy_bank: NUM_REGS must cover registers 0..5");
   end

   logic [REG_W-1:0] regs [NUM_REGS];
   logic [REG_W-1:0] ctl_nxt;
   logic             an_restart;

   function automatic logic [REG_W-1:0] rst_val(input int k);
      case (k)
         IDX_STS: return STS_RST;
         2:       return ID_HI;
         3:       return ID_LO;
         IDX_ADV: return ADV_RST;
         default: return '0;
      endcase
   endfunction

   always_comb begin
      ctl_nxt    = wr_data;
      an_restart = wr_en && (idx == IDX_W'(IDX_CTL)) && wr_data[CTL_ANRS_BIT];
      if (wr_data[CTL_RST_BIT]) begin
         ctl_nxt[CTL_RST_BIT]  = 1'b0;
         ctl_nxt[CTL_ANEN_BIT] = 1'b1;
      end
      ctl_nxt[CTL_ANRS_BIT] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_REGS; k++) regs[k] <= rst_val(k);
      end else begin
         if (wr_en) begin
            if (idx == IDX_W'(IDX_CTL)) regs[IDX_CTL] <= ctl_nxt;
            else                        regs[idx]     <= wr_data;
         end
         if (an_restart) begin
            regs[IDX_STS][STS_ANOK_BIT] <= 1'b1;
            if (link_s) begin
               regs[IDX_STS][STS_LINK_BIT]  <= 1'b1;
               regs[IDX_LPA][LPA_FD100_BIT] <= 1'b1;
            end
         end
         if (link_evt) begin
            regs[IDX_STS][STS_LINK_BIT]  <= link_s;
            regs[IDX_LPA][LPA_FD100_BIT] <= link_s;
         end
      end
   end

   assign rd_data = regs[idx];

   AST_CTL_RST_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IDX_W'(IDX_CTL) && wr_data[CTL_RST_BIT])
      |=> (regs[IDX_CTL][CTL_ANEN_BIT] && !regs[IDX_CTL][CTL_RST_BIT])); // R4

   AST_AN_RESTART_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      an_restart |=> (regs[IDX_STS][STS_ANOK_BIT] && !regs[IDX_CTL][CTL_ANRS_BIT])); // R5
endmodule

// File: rtl/mgmt_frame_if.sv
module mgmt_frame_if
   import mfi_pkg::*;
#(
   parameter int          NUM_REGS    = 32,
   parameter int          REG_W       = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [4:0]  PHY_ADDR    = 5'd1,
   parameter logic [15:0] ID_HI       = 16'h1234,
   parameter logic [15:0] ID_LO       = 16'h5670
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        link_up_a,
   input  logic        wr_en,
   input  logic        reg_sel,
   input  logic [31:0] wr_data,
   input  logic        stat_clr,
   output logic [31:0] frame_q,
   output logic [31:0] cfg_q,
   output logic [15:0] mgmt_status
);
   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS != 32) begin : g_bad_regs
      $error("mgmt_frame_if: the 5-bit register field needs NUM_REGS == 32");
   end

   logic             link_s, link_d, link_evt;
   logic             acc_ok, op_wr, op_rd;
   logic [IDX_W-1:0] reg_idx;
   logic [REG_W-1:0] bank_rd;
   logic             frm_wr, cfg_wr;
   logic [31:0]      frame_nxt;

   assign frm_wr = wr_en && !reg_sel;
   assign cfg_wr = wr_en &&  reg_sel;

   mfi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_a(link_up_a), .q(link_s));

   always_ff @(posedge clk) begin
      if (!rst_n) link_d <= 1'b0;
      else        link_d <= link_s;
   end
   assign link_evt = link_s ^ link_d;

   mfi_frame_dec #(.IDX_W(IDX_W), .PHY_ADDR(PHY_ADDR)) u_dec (
      .hdr(wr_data[31:HDR_LO]), .acc_ok(acc_ok), .op_wr(op_wr),
      .op_rd(op_rd), .reg_idx(reg_idx));

   mfi_phy_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W),
                  .ID_HI(ID_HI), .ID_LO(ID_LO)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(frm_wr && op_wr), .idx(reg_idx),
      .wr_data(wr_data[REG_W-1:0]), .link_s(link_s), .link_evt(link_evt),
      .rd_data(bank_rd));

   always_comb begin
      frame_nxt         = wr_data;
      frame_nxt[TA_LSB] = 1'b1;
      if (op_rd) frame_nxt[REG_W-1:0] = bank_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q     <= '0;
         cfg_q       <= CFG_RST;
         mgmt_status <= '0;
      end else begin
         if (frm_wr) frame_q <= frame_nxt;
         if (cfg_wr) cfg_q <= (wr_data & ~CFG_RO_MASK) | (cfg_q & CFG_RO_MASK);
         if (link_evt)      mgmt_status <= '1;
         else if (stat_clr) mgmt_status <= '0;
      end
   end

   AST_TA_SET: assert property (@(posedge clk) disable iff (!rst_n)
      frm_wr |=> frame_q[TA_LSB]); // R1

   AST_CFG_RO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> $stable(cfg_q[9:8])); // R6

   AST_LINK_STATUS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |=> (mgmt_status == 16'hFFFF)); // R8

   AST_RD_RETURNS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_wr && op_rd) |=> (frame_q[15:0] == $past(bank_rd))); // R3

   AST_NOACC_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_wr && !op_rd) |=> (frame_q[15:0] == $past(wr_data[15:0]))); // R2
endmodule

// File: tb/sim_mgmt_frame_if.sv
`timescale 1ns/1ps
module sim_mgmt_frame_if;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up_a = 1'b0;
   logic        wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        stat_clr = 1'b0;
   logic [31:0] frame_q, cfg_q;
   logic [15:0] mgmt_status;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mgmt_frame_if u0 (
      .clk(clk), .rst_n(rst_n), .link_up_a(link_up_a), .wr_en(wr_en),
      .reg_sel(reg_sel), .wr_data(wr_data), .stat_clr(stat_clr),
      .frame_q(frame_q), .cfg_q(cfg_q), .mgmt_status(mgmt_status));

   function automatic logic [31:0] mkf(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] pa, input logic [4:0] ra,
                                       input logic [15:0] d);
      return {st, op, pa, ra, 2'b00, d};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; reg_sel = 1'b0; wr_data = '0;
   endtask

   task automatic phy_wr(input logic [4:0] ra, input logic [15:0] d);
      wr(1'b0, mkf(2'b01, 2'b01, 5'd1, ra, d));
   endtask

   task automatic phy_rd(input logic [4:0] ra, output logic [15:0] d);
      wr(1'b0, mkf(2'b01, 2'b10, 5'd1, ra, 16'h0000));
      d = frame_q[15:0];
   endtask

   task automatic set_link(input logic v);
      @(negedge clk);
      link_up_a = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R7 frame", frame_q, 32'h0);
      chk("R6 cfg reset", cfg_q, 32'h0000_0100);
      chk("R7 status", {16'h0, mgmt_status}, 32'h0);
      phy_rd(5'd1, d); chk("R7 reg1", {16'h0, d}, 32'h4028);
      phy_rd(5'd2, d); chk("R7 reg2", {16'h0, d}, 32'h1234);
      phy_rd(5'd3, d); chk("R7 reg3", {16'h0, d}, 32'h5670);
      phy_rd(5'd4, d); chk("R7 reg4", {16'h0, d}, 32'h0100);
      phy_rd(5'd5, d); chk("R7 reg5", {16'h0, d}, 32'h0);
   endtask

   task automatic t_rw;
      logic [15:0] d;
      phy_wr(5'd7, 16'hA5C3);
      chk("R1 stored write frame", frame_q, mkf(2'b01, 2'b01, 5'd1, 5'd7, 16'hA5C3) | 32'h1_0000);
      phy_rd(5'd7, d);
      chk("R3 read data", {16'h0, d}, 32'h0000_A5C3);
      chk("R3 read frame upper", frame_q, mkf(2'b01, 2'b10, 5'd1, 5'd7, 16'hA5C3) | 32'h1_0000);
      phy_wr(5'd31, 16'h0F0F);
      phy_rd(5'd31, d);
      chk("R3 last register", {16'h0, d}, 32'h0F0F);
   endtask

   task automatic t_reject;
      logic [15:0] d;
      logic [31:0] f;
      f = mkf(2'b01, 2'b01, 5'd2, 5'd4, 16'hBEEF);
      wr(1'b0, f);
      chk("R2 wrong addr stored", frame_q, f | 32'h1_0000);
      f = mkf(2'b00, 2'b01, 5'd1, 5'd4, 16'hBEEF);
      wr(1'b0, f);
      chk("R2 bad start stored", frame_q, f | 32'h1_0000);
      f = mkf(2'b01, 2'b10, 5'd0, 5'd4, 16'h1357);
      wr(1'b0, f);
      chk("R2 rejected read keeps data", frame_q, f | 32'h1_0000);
      phy_rd(5'd4, d);
      chk("R2 reg4 untouched", {16'h0, d}, 32'h0100);
   endtask

   task automatic t_noop;
      logic [15:0] d;
      logic [31:0] f;
      f = mkf(2'b01, 2'b11, 5'd1, 5'd4, 16'h1111);
      wr(1'b0, f);
      chk("R9 op11 stored", frame_q, f | 32'h1_0000);
      f = mkf(2'b01, 2'b00, 5'd1, 5'd4, 16'h2222);
      wr(1'b0, f);
      chk("R9 op00 stored", frame_q, f | 32'h1_0000);
      phy_rd(5'd4, d);
      chk("R9 reg4 untouched", {16'h0, d}, 32'h0100);
   endtask

   task automatic t_ctl;
      logic [15:0] d;
      phy_wr(5'd0, 16'h8000);
      phy_rd(5'd0, d); chk("R4 reset autoclear", {16'h0, d}, 32'h1000);
      phy_wr(5'd0, 16'h0040);
      phy_rd(5'd0, d); chk("R4 plain write", {16'h0, d}, 32'h0040);
      phy_wr(5'd1, 16'h0000);
      phy_wr(5'd0, 16'h0200);
      phy_rd(5'd0, d); chk("R5 restart autoclear", {16'h0, d}, 32'h0000);
      phy_rd(5'd1, d); chk("R5 link down reg1", {16'h0, d}, 32'h0020);
      phy_rd(5'd5, d); chk("R5 link down reg5", {16'h0, d}, 32'h0000);
   endtask

   task automatic t_link;
      logic [15:0] d;
      set_link(1'b1);
      chk("R8 status ones", {16'h0, mgmt_status}, 32'hFFFF);
      phy_rd(5'd1, d); chk("R8 link up reg1", {16'h0, d}, 32'h0024);
      phy_rd(5'd5, d); chk("R8 link up reg5", {16'h0, d}, 32'h0100);
      @(negedge clk); stat_clr = 1'b1;
      @(negedge clk); stat_clr = 1'b0;
      chk("R8 status cleared", {16'h0, mgmt_status}, 32'h0);
      phy_wr(5'd1, 16'h0000);
      phy_wr(5'd5, 16'h0000);
      phy_wr(5'd0, 16'h8200);
      phy_rd(5'd0, d); chk("R4 combined", {16'h0, d}, 32'h1000);
      phy_rd(5'd1, d); chk("R5 link up reg1", {16'h0, d}, 32'h0024);
      phy_rd(5'd5, d); chk("R5 link up reg5", {16'h0, d}, 32'h0100);
      set_link(1'b0);
      phy_rd(5'd1, d); chk("R8 link down reg1", {16'h0, d}, 32'h0020);
      phy_rd(5'd5, d); chk("R8 link down reg5", {16'h0, d}, 32'h0000);
      chk("R8 status on fall", {16'h0, mgmt_status}, 32'hFFFF);
   endtask

   task automatic t_cfg;
      wr(1'b1, 32'h0000_0000);
      chk("R6 cfg zero write", cfg_q, 32'h0000_0100);
      wr(1'b1, 32'hFFFF_FFFF);
      chk("R6 cfg ones write", cfg_q, 32'hFFFF_FDFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_rw;
      t_reject;
      t_noop;
      t_ctl;
      t_link;
      t_cfg;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule